// File: doc/BRIEF.md
# SD Sector Transfer Status Responder

This block stands between a host that polls a memory-mapped buffer and a storage back end that moves whole sectors. An upstream register decoder hands it three kinds of event: control writes (enable and read-arm bits), transfer commands (start sector plus a 16-bit count word), and host accesses to the data buffer window. The window holds up to `MAX_BLK` sectors of `SECTOR_HW` halfwords each. Halfword offset 0 of the window also serves as the status word.

Once a command is accepted, the block raises a request toward the storage side. The request carries the start sector, the block count and the direction. Until the storage side answers with a ready pulse, a host read of the status word returns the busy code 0xEEE1 in place of the buffer contents. Any other value tells the host the transfer has finished.

After a read, the status word is simply the first data halfword that the storage side placed in the buffer. After a write, it is a fixed completion code. Clearing the enable bit abandons any transfer in progress.

Top module: `sdx_status_responder`

## Requirements
- R1: After reset no storage request is raised and the enable bit is clear, so commands have no effect until a control write sets control bit 0.
- R2: A command issued while enable is clear is ignored: no request appears and a status read returns buffer word 0, not the busy code.
- R3: A read command (count word bit 15 = 0) is accepted only for a block count of 1 to `MAX_BLK`. A count of 0 or above `MAX_BLK` is rejected: the block returns to idle and raises no request.
- R4: A write is flagged by bit 15 of the count word. It is accepted only with a block count (bits 14:0) of exactly 1; any other count is rejected.
- R5: An accepted read waits for the arm bit (control value 3, bits 0 and 1 both set) before it raises a request. While it waits, the status word reads busy.
- R6: The request presents the command's start sector, block count and direction. These stay stable for as long as the request is held, and the request drops in the cycle after the ready pulse.
- R7: While a transfer waits or is pending, a host read at halfword offset 0 returns 0xEEE1, even if buffer word 0 has already been written.
- R8: After a read completes, host reads return buffer contents one cycle after the read strobe. Halfword w of block b sits at offset b*`SECTOR_HW`+w, and offset 0 returns the first data halfword.
- R9: After a write completes, the status word returns `WR_DONE_CODE`. During the write, the storage fetch port returns the halfwords the host placed in the buffer, one cycle after the fetch address.
- R10: A control write with bit 0 clear aborts any pending transfer. The request drops in the next cycle and the status word no longer reads busy.
- R11: A command that arrives while a request is pending is ignored. The presented sector, count and direction do not change.
- R12: A newly accepted command clears a completed state, so the status word reads busy again until the new transfer finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_val | input | 2 | Control value: bit 0 enable, bit 1 read arm |
| cmd_valid | input | 1 | Transfer command strobe |
| cmd_sector | input | 32 | Start sector of the command |
| cmd_count | input | 16 | Bit 15 write flag, bits 14:0 block count |
| host_rd | input | 1 | Host buffer read strobe |
| host_wr | input | 1 | Host buffer write strobe |
| host_addr | input | AW | Halfword offset inside the buffer window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid one cycle after host_rd |
| st_req | output | 1 | Storage request, held until st_ready |
| st_sector | output | 32 | Requested start sector |
| st_blocks | output | CW | Requested block count |
| st_write | output | 1 | Request direction, 1 for write |
| st_ready | input | 1 | Storage completion pulse |
| st_fill_en | input | 1 | Storage buffer write strobe (read data) |
| st_fill_addr | input | AW | Storage buffer write offset |
| st_fill_data | input | 16 | Storage buffer write data |
| st_fetch_addr | input | AW | Storage buffer read offset (write data) |
| st_fetch_data | output | 16 | Buffer halfword at st_fetch_addr, one cycle later |

## Verification
The bench builds the block with `SECTOR_HW` = 16 and `MAX_BLK` = 4, which gives a 64-halfword window. With that size every halfword of a four-block read can be filled and checked in a few dozen cycles. A rejection test with a count of 5 then lands exactly one past the limit. Keeping `MAX_BLK` at its default also exercises the full three-bit count field of the request, so both the legal maximum and the first illegal count are reachable.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    localparam logic [15:0] SX_BUSY_CODE = 16'hEEE1;

    typedef enum logic [1:0] {
        SX_IDLE     = 2'd0,
        SX_WAIT_ARM = 2'd1,
        SX_PEND     = 2'd2,
        SX_DONE     = 2'd3
    } sx_state_e;

    typedef struct packed {
        logic [31:0] sector;
        logic [14:0] blocks;
        logic        write;
    } sx_cmd_t;

endpackage

// File: rtl/sdx_cmd_check.sv
module sdx_cmd_check #(
    parameter int MAX_BLK = 4
) (
    input  logic [15:0] count_word,
    output logic        is_write,
    output logic [14:0] blocks,
    output logic        legal
);
    // Bit 15 selects direction; a write moves one block, a read 1..MAX_BLK.
    always_comb begin
        is_write = count_word[15];
        blocks   = count_word[14:0];
        if (is_write) begin
            legal = (blocks == 15'd1);
        end else begin
            legal = (blocks != 15'd0) && (32'(blocks) <= 32'(MAX_BLK));
        end
    end
endmodule

// File: rtl/sdx_seq.sv
module sdx_seq
    import sdx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic [1:0] ctrl_val,
    input  logic      cmd_valid,
    input  sx_cmd_t   cmd_in,
    input  logic      cmd_legal,
    input  logic      st_ready,
    output sx_state_e state,
    output sx_cmd_t   cur_cmd
);
    typedef struct packed {
        sx_state_e state;
        logic      en;
        logic      arm;
        sx_cmd_t   cmd;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            SX_IDLE, SX_WAIT_ARM, SX_DONE: begin
                if (cmd_valid && seq_q.en) begin
                    if (cmd_legal) begin
                        seq_d.cmd   = cmd_in;
                        seq_d.state = (cmd_in.write || seq_q.arm) ? SX_PEND : SX_WAIT_ARM;
                    end else begin
                        seq_d.state = SX_IDLE;
                    end
                end else if (seq_q.state == SX_WAIT_ARM && seq_q.arm) begin
                    seq_d.state = SX_PEND;
                end
            end
            SX_PEND: begin
                if (st_ready) begin
                    seq_d.state = SX_DONE;
                end
            end
            default: seq_d.state = SX_IDLE;
        endcase
        // A control write overrides everything; clearing enable aborts.
        if (ctrl_wr) begin
            seq_d.en  = ctrl_val[0];
            seq_d.arm = ctrl_val[0] & ctrl_val[1];
            if (!ctrl_val[0]) begin
                seq_d.state = SX_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: SX_IDLE, en: 1'b0, arm: 1'b0, cmd: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state   = seq_q.state;
    assign cur_cmd = seq_q.cmd;
endmodule

// File: rtl/sdx_buffer.sv
module sdx_buffer #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [15:0]   a_wdata,
    output logic [15:0]   a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_waddr,
    input  logic [15:0]   b_wdata,
    input  logic [AW-1:0] b_raddr,
    output logic [15:0]   b_rdata
);
    logic [15:0] mem [DEPTH];

    // Storage-side write is ordered after the host write on a shared address.
    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
        if (b_we) begin
            mem[b_waddr] <= b_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (a_re) begin
            a_rdata <= mem[a_addr];
        end
    end

    always_ff @(posedge clk) begin
        b_rdata <= mem[b_raddr];
    end
endmodule

// File: rtl/sdx_status_responder.sv
module sdx_status_responder
    import sdx_pkg::*;
#(
    parameter int          SECTOR_HW    = 256,
    parameter int          MAX_BLK      = 4,
    parameter logic [15:0] WR_DONE_CODE = 16'h0000,
    localparam int         DEPTH        = SECTOR_HW * MAX_BLK,
    localparam int         AW           = $clog2(DEPTH),
    localparam int         CW           = $clog2(MAX_BLK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [1:0]    ctrl_val,
    input  logic          cmd_valid,
    input  logic [31:0]   cmd_sector,
    input  logic [15:0]   cmd_count,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    output logic          st_req,
    output logic [31:0]   st_sector,
    output logic [CW-1:0] st_blocks,
    output logic          st_write,
    input  logic          st_ready,
    input  logic          st_fill_en,
    input  logic [AW-1:0] st_fill_addr,
    input  logic [15:0]   st_fill_data,
    input  logic [AW-1:0] st_fetch_addr,
    output logic [15:0]   st_fetch_data
);
    logic        cmd_is_write;
    logic [14:0] cmd_blocks;
    logic        cmd_legal;
    sx_cmd_t     cmd_in;
    sx_state_e   state;
    sx_cmd_t     cur_cmd;
    logic [15:0] buf_rdata;

    sdx_cmd_check #(.MAX_BLK(MAX_BLK)) u_check (
        .count_word (cmd_count),
        .is_write   (cmd_is_write),
        .blocks     (cmd_blocks),
        .legal      (cmd_legal)
    );

    assign cmd_in = '{sector: cmd_sector, blocks: cmd_blocks, write: cmd_is_write};

    sdx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_val  (ctrl_val),
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_in),
        .cmd_legal (cmd_legal),
        .st_ready  (st_ready),
        .state     (state),
        .cur_cmd   (cur_cmd)
    );

    sdx_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk     (clk),
        .a_we    (host_wr),
        .a_re    (host_rd),
        .a_addr  (host_addr),
        .a_wdata (host_wdata),
        .a_rdata (buf_rdata),
        .b_we    (st_fill_en),
        .b_waddr (st_fill_addr),
        .b_wdata (st_fill_data),
        .b_raddr (st_fetch_addr),
        .b_rdata (st_fetch_data)
    );

    // Status override captured alongside the buffer read.
    typedef struct packed {
        logic busy;
        logic wrok;
    } ovr_t;

    ovr_t ovr_d, ovr_q;

    always_comb begin
        ovr_d = ovr_q;
        if (host_rd) begin
            ovr_d.busy = (host_addr == '0) &&
                         (state == SX_WAIT_ARM || state == SX_PEND);
            ovr_d.wrok = (host_addr == '0) && (state == SX_DONE) && cur_cmd.write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= '0;
        end else begin
            ovr_q <= ovr_d;
        end
    end

    assign host_rdata = ovr_q.busy ? SX_BUSY_CODE :
                        ovr_q.wrok ? WR_DONE_CODE : buf_rdata;

    assign st_req    = (state == SX_PEND);
    assign st_sector = cur_cmd.sector;
    assign st_blocks = cur_cmd.blocks[CW-1:0];
    assign st_write  = cur_cmd.write;
endmodule

// File: rtl/sdx_status_checker.sv
module sdx_status_checker #(
    parameter int MAX_BLK = 4,
    parameter int AW      = 10,
    parameter int CW      = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_wr,
    input logic [1:0]    ctrl_val,
    input logic          cmd_valid,
    input logic          host_rd,
    input logic [AW-1:0] host_addr,
    input logic [15:0]   host_rdata,
    input logic          st_req,
    input logic [31:0]   st_sector,
    input logic [CW-1:0] st_blocks,
    input logic          st_write,
    input logic          st_ready
);
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !ctrl_val[0] |=> !st_req);

    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && st_ready && !cmd_valid |=> !st_req);

    assert_legal_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (st_blocks != '0) && (32'(st_blocks) <= 32'(MAX_BLK)));

    assert_write_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && st_write |-> st_blocks == CW'(1));

    assert_busy_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == '0 && st_req |=> host_rdata == 16'hEEE1);

    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && $past(st_req) |-> $stable(st_sector) && $stable(st_blocks) && $stable(st_write));
endmodule

bind sdx_status_responder sdx_status_checker #(.MAX_BLK(MAX_BLK), .AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_val   (ctrl_val),
    .cmd_valid  (cmd_valid),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .st_req     (st_req),
    .st_sector  (st_sector),
    .st_blocks  (st_blocks),
    .st_write   (st_write),
    .st_ready   (st_ready)
);

// File: tb/sdx_status_responder_test.sv
`timescale 1ns/1ps
module sdx_status_responder_test;
    localparam int SHW   = 16;
    localparam int MB    = 4;
    localparam int DEPTH = SHW * MB;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(MB + 1);
    localparam logic [15:0] BUSY = 16'hEEE1;
    localparam logic [15:0] WOK  = 16'h0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [1:0]    ctrl_val = '0;
    logic          cmd_valid = 1'b0;
    logic [31:0]   cmd_sector = '0;
    logic [15:0]   cmd_count = '0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic          st_req;
    logic [31:0]   st_sector;
    logic [CW-1:0] st_blocks;
    logic          st_write;
    logic          st_ready = 1'b0;
    logic          st_fill_en = 1'b0;
    logic [AW-1:0] st_fill_addr = '0;
    logic [15:0]   st_fill_data = '0;
    logic [AW-1:0] st_fetch_addr = '0;
    logic [15:0]   st_fetch_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] wbuf [DEPTH];

    always #2 clk = ~clk;

    sdx_status_responder #(.SECTOR_HW(SHW), .MAX_BLK(MB), .WR_DONE_CODE(WOK)) uut (.*);

    function automatic logic [15:0] pat(input logic [31:0] sec, input int idx);
        return sec[15:0] ^ 16'(idx * 16'h9E37) ^ 16'h0101;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [1:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_val = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic send_cmd(input logic [31:0] sec, input logic [15:0] cnt);
        @(negedge clk); cmd_valid = 1'b1; cmd_sector = sec; cmd_count = cnt;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic hread(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk); host_rd = 1'b1; host_addr = a;
        @(negedge clk); host_rd = 1'b0; d = host_rdata;
    endtask

    task automatic hwrite(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk); st_ready = 1'b1;
        @(negedge clk); st_ready = 1'b0;
    endtask

    task automatic fill(input logic [31:0] sec, input int nblk);
        for (int i = 0; i < nblk * SHW; i++) begin
            @(negedge clk); st_fill_en = 1'b1; st_fill_addr = AW'(i); st_fill_data = pat(sec, i);
        end
        @(negedge clk); st_fill_en = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] sec, input int nblk);
        logic [15:0] d;
        int a;
        send_cmd(sec, 16'(nblk));
        chk(st_req === 1'b1, "R6 read request raised", 32'(st_req), 1);
        chk(st_sector === sec, "R6 request sector", st_sector, sec);
        chk(32'(st_blocks) == nblk && st_write === 1'b0, "R6 request count/dir", 32'(st_blocks), nblk);
        fill(sec, nblk);
        hread('0, d);
        chk(d === BUSY, "R7 busy while pending after fill", 32'(d), 32'(BUSY));
        pulse_ready();
        chk(st_req === 1'b0, "R6 request drops after ready", 32'(st_req), 0);
        hread('0, d);
        chk(d === pat(sec, 0), "R8 status shows first data word", 32'(d), 32'(pat(sec, 0)));
        a = 32'($urandom_range(nblk * SHW - 1));
        hread(AW'(a), d);
        chk(d === pat(sec, a), "R8 buffer word readback", 32'(d), 32'(pat(sec, a)));
    endtask

    task automatic do_write(input logic [31:0] sec);
        logic [15:0] d;
        for (int i = 0; i < SHW; i++) begin
            wbuf[i] = 16'($urandom);
            hwrite(AW'(i), wbuf[i]);
        end
        send_cmd(sec, 16'h8001);
        chk(st_req === 1'b1 && st_write === 1'b1, "R4 write request raised", {st_req, st_write}, 3);
        chk(st_sector === sec && st_blocks == CW'(1), "R6 write request fields", st_sector, sec);
        hread('0, d);
        chk(d === BUSY, "R7 busy during write", 32'(d), 32'(BUSY));
        for (int i = 0; i < SHW; i += 5) begin
            @(negedge clk); st_fetch_addr = AW'(i);
            @(negedge clk);
            chk(st_fetch_data === wbuf[i], "R9 fetch port data", 32'(st_fetch_data), 32'(wbuf[i]));
        end
        pulse_ready();
        hread('0, d);
        chk(d === WOK, "R9 write completion code", 32'(d), 32'(WOK));
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [31:0] s0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(st_req === 1'b0, "R1 no request after reset", 32'(st_req), 0);

        // R1/R2: commands ignored while not enabled
        hwrite('0, 16'h1234);
        send_cmd(32'h10, 16'd2);
        chk(st_req === 1'b0, "R2 no request while disabled", 32'(st_req), 0);
        hread('0, d);
        chk(d === 16'h1234, "R2 status not busy while disabled", 32'(d), 32'h1234);

        // R5: read without arm waits busy
        set_ctrl(2'b01);
        send_cmd(32'h55, 16'd1);
        chk(st_req === 1'b0, "R5 no request without arm", 32'(st_req), 0);
        hread('0, d);
        chk(d === BUSY, "R5 busy while awaiting arm", 32'(d), 32'(BUSY));
        set_ctrl(2'b11);
        @(negedge clk);
        chk(st_req === 1'b1 && st_sector == 32'h55, "R5 request after arm", st_sector, 32'h55);
        // R11: command during pending ignored
        send_cmd(32'h99, 16'd3);
        chk(st_sector == 32'h55 && st_blocks == CW'(1), "R11 pending command ignored", st_sector, 32'h55);
        // R10: abort
        set_ctrl(2'b00);
        chk(st_req === 1'b0, "R10 abort drops request", 32'(st_req), 0);
        hread('0, d);
        chk(d !== BUSY, "R10 status not busy after abort", 32'(d), 32'(BUSY));

        // R3/R4: rejected counts
        set_ctrl(2'b11);
        send_cmd(32'h7, 16'd0);
        chk(st_req === 1'b0, "R3 count zero rejected", 32'(st_req), 0);
        send_cmd(32'h7, 16'(MB + 1));
        chk(st_req === 1'b0, "R3 count above max rejected", 32'(st_req), 0);
        hread('0, d);
        chk(d !== BUSY, "R3 idle after rejection", 32'(d), 32'(BUSY));
        send_cmd(32'h7, 16'h8002);
        chk(st_req === 1'b0, "R4 write count two rejected", 32'(st_req), 0);
        send_cmd(32'h7, 16'h8000);
        chk(st_req === 1'b0, "R4 write count zero rejected", 32'(st_req), 0);

        // Directed boundary: full-size read
        do_read(32'hABCD0000, MB);
        // R12: a new command re-arms busy
        send_cmd(32'h42, 16'd1);
        hread('0, d);
        chk(d === BUSY, "R12 new command clears done", 32'(d), 32'(BUSY));
        fill(32'h42, 1);
        pulse_ready();

        // Random mix
        for (int it = 0; it < 12; it++) begin
            s0 = $urandom;
            if ($urandom_range(1) == 0) begin
                set_ctrl(2'b11);
                do_read(s0, 32'($urandom_range(MB, 1)));
            end else begin
                set_ctrl(2'b01);
                do_write(s0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule